// File: doc/BRIEF.md
# Erase-Count Wear Leveler

This block tracks how many times each physical flash block has been erased and, on request, pairs the most-worn healthy block with the least-worn one. Each erase completion arrives as a one-cycle event that carries a block index. The block then advances that block's counter. A block whose counter reaches the wear limit is retired for good and takes no further part in leveling.

When the controller pulses the trigger, the block walks the counters, one block per clock. It skips retired blocks and keeps the lowest and highest counts it sees. At the end of the walk it raises a one-cycle completion pulse. If the spread between the highest and lowest count is larger than the programmable threshold, a swap request naming both physical blocks goes out in that same cycle. At the next edge the logical-to-physical block table exchanges the two affected entries. Moving the data on the flash itself is done elsewhere.

Top module: `wl_swapper`

## Requirements
- R1: After reset every erase counter reads 0, no block is retired, busy_o is low, and the block table maps each logical block L to physical block L.
- R2: An erase event on a block that is not retired raises that block's counter by exactly one at the next clock edge. Other counters do not change.
- R3: When a counter reaches WEAR_LIMIT, the block's bit in failed_o is set and stays set. Later erase events on that block leave its counter at WEAR_LIMIT.
- R4: A trigger while idle starts a walk. busy_o is then high for exactly NUM_BLK+1 cycles, and done_o is high for only the last of them. A trigger while busy_o is high is ignored.
- R5: The reported swap_min_o and swap_max_o are the blocks with the lowest and highest erase counts.
- R6: When several blocks share the lowest or the highest count, the block with the lowest index is reported.
- R7: Retired blocks are never chosen as swap_min_o or swap_max_o.
- R8: swap_valid_o is high with done_o only when the highest count minus the lowest count is strictly greater than thresh_i. Otherwise done_o rises alone and the block table is left unchanged.
- R9: After a swap, the logical block that mapped to swap_min_o maps to swap_max_o, and the reverse. This is visible on lookup_pblk_o from the cycle after done_o. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| erase_valid_i | input | 1 | One-cycle erase completion event |
| erase_blk_i | input | IDX_W | Physical block that was erased |
| trig_i | input | 1 | Start a leveling walk |
| thresh_i | input | CNT_W | Minimum spread to exceed before a swap is issued |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| swap_valid_o | output | 1 | Swap request, valid with done_o |
| swap_min_o | output | IDX_W | Least-worn healthy physical block |
| swap_max_o | output | IDX_W | Most-worn healthy physical block |
| failed_o | output | NUM_BLK | Retired block map, one bit per block |
| rd_blk_i | input | IDX_W | Block whose counter is read |
| rd_cnt_o | output | CNT_W | Erase counter of rd_blk_i |
| lookup_lblk_i | input | IDX_W | Logical block to translate |
| lookup_pblk_o | output | IDX_W | Physical block mapped to lookup_lblk_i |

## Verification
A corrupted counter shows on rd_cnt_o one cycle after the erase event. A corrupted counter also shows as a wrong block pair at the next done_o. A stuck or mis-sequenced walk shows as a busy_o window that differs from NUM_BLK+1 cycles, or as a missing or doubled done_o. A damaged block table shows on lookup_pblk_o in the cycle after done_o, because the bench keeps its own copy of the map and compares every entry after each walk.

// File: rtl/wl_pkg.sv
package wl_pkg;
  typedef enum logic [1:0] {
    WL_IDLE = 2'd0,
    WL_SCAN = 2'd1,
    WL_DONE = 2'd2
  } wl_state_e;
endpackage

// File: rtl/wl_wear_bank.sv
module wl_wear_bank #(
  parameter int NUM_BLK    = 8,
  parameter int CNT_W      = 17,
  parameter int WEAR_LIMIT = 100000,
  localparam int IDX_W     = $clog2(NUM_BLK)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           erase_valid_i,
  input  logic [IDX_W-1:0]               erase_blk_i,
  input  logic [IDX_W-1:0]               rd_blk_i,
  output logic [CNT_W-1:0]               rd_cnt_o,
  output logic [NUM_BLK-1:0][CNT_W-1:0]  cnt_o,
  output logic [NUM_BLK-1:0]             failed_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WEAR_LIMIT - 1);

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_blk
    logic hit;
    assign hit = erase_valid_i && (erase_blk_i == IDX_W'(i)) && !failed_o[i];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_o[i]    <= '0;
        failed_o[i] <= 1'b0;
      end else if (hit) begin
        cnt_o[i] <= cnt_o[i] + 1'b1;
        // the erase that reaches the limit retires the block
        if (cnt_o[i] == LAST_CNT) failed_o[i] <= 1'b1;
      end
    end
  end

  assign rd_cnt_o = cnt_o[rd_blk_i];
endmodule

// File: rtl/wl_scan.sv
module wl_scan
  import wl_pkg::*;
#(
  parameter int NUM_BLK = 8,
  parameter int CNT_W   = 17,
  localparam int IDX_W  = $clog2(NUM_BLK)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          trig_i,
  input  logic [CNT_W-1:0]              thresh_i,
  input  logic [NUM_BLK-1:0][CNT_W-1:0] cnt_i,
  input  logic [NUM_BLK-1:0]            failed_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic                          swap_valid_o,
  output logic [IDX_W-1:0]              swap_min_o,
  output logic [IDX_W-1:0]              swap_max_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLK - 1);

  wl_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             found_q;
  logic [CNT_W-1:0] min_cnt_q, max_cnt_q;
  logic [IDX_W-1:0] min_idx_q, max_idx_q;
  logic [CNT_W-1:0] cur_cnt;
  logic             cur_ok;
  logic [CNT_W-1:0] spread;

  assign cur_cnt = cnt_i[idx_q];
  assign cur_ok  = !failed_i[idx_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= WL_IDLE;
      idx_q     <= '0;
      found_q   <= 1'b0;
      min_cnt_q <= '0;
      max_cnt_q <= '0;
      min_idx_q <= '0;
      max_idx_q <= '0;
    end else begin
      unique case (state_q)
        WL_IDLE: begin
          if (trig_i) begin
            state_q <= WL_SCAN;
            idx_q   <= '0;
            found_q <= 1'b0;
          end
        end
        WL_SCAN: begin
          if (cur_ok) begin
            found_q <= 1'b1;
            // strict compares on an ascending walk keep the lowest index on ties
            if (!found_q || cur_cnt < min_cnt_q) begin
              min_cnt_q <= cur_cnt;
              min_idx_q <= idx_q;
            end
            if (!found_q || cur_cnt > max_cnt_q) begin
              max_cnt_q <= cur_cnt;
              max_idx_q <= idx_q;
            end
          end
          if (idx_q == LAST_IDX) state_q <= WL_DONE;
          else                   idx_q   <= idx_q + 1'b1;
        end
        WL_DONE: state_q <= WL_IDLE;
        default: state_q <= WL_IDLE;
      endcase
    end
  end

  assign spread       = max_cnt_q - min_cnt_q;
  assign busy_o       = (state_q != WL_IDLE);
  assign done_o       = (state_q == WL_DONE);
  assign swap_valid_o = done_o && found_q && (spread > thresh_i);
  assign swap_min_o   = min_idx_q;
  assign swap_max_o   = max_idx_q;
endmodule

// File: rtl/wl_map.sv
module wl_map #(
  parameter int NUM_BLK = 8,
  localparam int IDX_W  = $clog2(NUM_BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             swap_i,
  input  logic [IDX_W-1:0] pa_i,
  input  logic [IDX_W-1:0] pb_i,
  input  logic [IDX_W-1:0] lookup_lblk_i,
  output logic [IDX_W-1:0] lookup_pblk_o
);
  logic [NUM_BLK-1:0][IDX_W-1:0] l2p_q;
  logic [NUM_BLK-1:0][IDX_W-1:0] p2l_q;
  logic [IDX_W-1:0]              la, lb;

  // inverse table gives the owners of both physical blocks in one cycle
  assign la = p2l_q[pa_i];
  assign lb = p2l_q[pb_i];

  for (genvar i = 0; i < NUM_BLK; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        l2p_q[i] <= IDX_W'(i);
        p2l_q[i] <= IDX_W'(i);
      end else if (swap_i) begin
        if (la == IDX_W'(i))      l2p_q[i] <= pb_i;
        else if (lb == IDX_W'(i)) l2p_q[i] <= pa_i;
        if (pa_i == IDX_W'(i))      p2l_q[i] <= lb;
        else if (pb_i == IDX_W'(i)) p2l_q[i] <= la;
      end
    end
  end

  assign lookup_pblk_o = l2p_q[lookup_lblk_i];
endmodule

// File: rtl/wl_swapper.sv
module wl_swapper #(
  parameter int NUM_BLK    = 8,
  parameter int CNT_W      = 17,
  parameter int WEAR_LIMIT = 100000,
  localparam int IDX_W     = $clog2(NUM_BLK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               erase_valid_i,
  input  logic [IDX_W-1:0]   erase_blk_i,
  input  logic               trig_i,
  input  logic [CNT_W-1:0]   thresh_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               swap_valid_o,
  output logic [IDX_W-1:0]   swap_min_o,
  output logic [IDX_W-1:0]   swap_max_o,
  output logic [NUM_BLK-1:0] failed_o,
  input  logic [IDX_W-1:0]   rd_blk_i,
  output logic [CNT_W-1:0]   rd_cnt_o,
  input  logic [IDX_W-1:0]   lookup_lblk_i,
  output logic [IDX_W-1:0]   lookup_pblk_o
);
  logic [NUM_BLK-1:0][CNT_W-1:0] cnt;

  wl_wear_bank #(
    .NUM_BLK   (NUM_BLK),
    .CNT_W     (CNT_W),
    .WEAR_LIMIT(WEAR_LIMIT)
  ) u_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .erase_valid_i(erase_valid_i),
    .erase_blk_i  (erase_blk_i),
    .rd_blk_i     (rd_blk_i),
    .rd_cnt_o     (rd_cnt_o),
    .cnt_o        (cnt),
    .failed_o     (failed_o)
  );

  wl_scan #(
    .NUM_BLK(NUM_BLK),
    .CNT_W  (CNT_W)
  ) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .thresh_i    (thresh_i),
    .cnt_i       (cnt),
    .failed_i    (failed_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .swap_valid_o(swap_valid_o),
    .swap_min_o  (swap_min_o),
    .swap_max_o  (swap_max_o)
  );

  wl_map #(
    .NUM_BLK(NUM_BLK)
  ) u_map (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .swap_i       (swap_valid_o),
    .pa_i         (swap_min_o),
    .pb_i         (swap_max_o),
    .lookup_lblk_i(lookup_lblk_i),
    .lookup_pblk_o(lookup_pblk_o)
  );
endmodule

// File: rtl/wl_swapper_chk.sv
module wl_swapper_chk #(
  parameter int NUM_BLK = 8,
  localparam int IDX_W  = $clog2(NUM_BLK)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               busy_o,
  input logic               done_o,
  input logic               swap_valid_o,
  input logic [IDX_W-1:0]   swap_min_o,
  input logic [IDX_W-1:0]   swap_max_o,
  input logic [NUM_BLK-1:0] failed_o
);
  assert_done_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_in_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  assert_idle_after_done_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  assert_swap_with_done_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_valid_o |-> done_o);

  assert_swap_distinct_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_valid_o |-> (swap_min_o != swap_max_o));

  assert_swap_healthy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_valid_o |-> (!failed_o[swap_min_o] && !failed_o[swap_max_o]));

  assert_failed_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (failed_o & $past(failed_o)) == $past(failed_o));
endmodule

bind wl_swapper wl_swapper_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .swap_valid_o(swap_valid_o),
  .swap_min_o  (swap_min_o),
  .swap_max_o  (swap_max_o),
  .failed_o    (failed_o)
);

// File: tb/wl_swapper_test.sv
module wl_swapper_test;
  localparam int N   = 8;
  localparam int CW  = 8;
  localparam int LIM = 20;
  localparam int IW  = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          erase_valid = 1'b0;
  logic [IW-1:0] erase_blk = '0;
  logic          trig = 1'b0;
  logic [CW-1:0] thresh = '0;
  logic          busy_o, done_o, swap_valid_o;
  logic [IW-1:0] swap_min_o, swap_max_o;
  logic [N-1:0]  failed_o;
  logic [IW-1:0] rd_blk = '0;
  logic [CW-1:0] rd_cnt_o;
  logic [IW-1:0] lk_l = '0;
  logic [IW-1:0] lk_p_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ended  = 1'b0;

  int m_cnt [N];
  bit m_fail[N];
  int m_l2p [N];
  logic [2*IW:0] exp_q[$];

  always #5 clk = ~clk;

  wl_swapper #(.NUM_BLK(N), .CNT_W(CW), .WEAR_LIMIT(LIM)) uut (
    .clk_i(clk), .rst_ni(rst_n), .erase_valid_i(erase_valid), .erase_blk_i(erase_blk),
    .trig_i(trig), .thresh_i(thresh), .busy_o(busy_o), .done_o(done_o),
    .swap_valid_o(swap_valid_o), .swap_min_o(swap_min_o), .swap_max_o(swap_max_o),
    .failed_o(failed_o), .rd_blk_i(rd_blk), .rd_cnt_o(rd_cnt_o),
    .lookup_lblk_i(lk_l), .lookup_pblk_o(lk_p_o)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  // monitor: pop expected result on each done pulse
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        chk("R4 unexpected done", 1, 0);
      end else begin
        logic [2*IW:0] e;
        e = exp_q.pop_front();
        chk("R8 swap_valid", int'(swap_valid_o), int'(e[2*IW]));
        if (e[2*IW]) begin
          chk("R5 R6 R7 swap_min", int'(swap_min_o), int'(e[2*IW-1:IW]));
          chk("R5 R6 R7 swap_max", int'(swap_max_o), int'(e[IW-1:0]));
        end
      end
    end
  end

  task automatic erase(int b, int times);
    for (int k = 0; k < times; k++) begin
      @(negedge clk);
      erase_valid = 1'b1;
      erase_blk   = IW'(b);
      if (!m_fail[b]) begin
        m_cnt[b]++;
        if (m_cnt[b] == LIM) m_fail[b] = 1'b1;
      end
    end
    @(negedge clk);
    erase_valid = 1'b0;
  endtask

  task automatic check_counts(string req);
    for (int b = 0; b < N; b++) begin
      rd_blk = IW'(b);
      #1;
      chk(req, int'(rd_cnt_o), m_cnt[b]);
    end
  endtask

  task automatic check_map(string req);
    for (int l = 0; l < N; l++) begin
      lk_l = IW'(l);
      #1;
      chk(req, int'(lk_p_o), m_l2p[l]);
    end
  endtask

  // driver: compute the expected pair, push it, run one walk
  task automatic level(int th, bit poke_busy);
    int mn, mx, mi, xi, nbusy;
    bit found, ok;
    found = 1'b0; mn = 0; mx = 0; mi = 0; xi = 0;
    for (int b = 0; b < N; b++) begin
      if (!m_fail[b]) begin
        if (!found || m_cnt[b] < mn) begin mn = m_cnt[b]; mi = b; end
        if (!found || m_cnt[b] > mx) begin mx = m_cnt[b]; xi = b; end
        found = 1'b1;
      end
    end
    ok = found && ((mx - mn) > th);
    exp_q.push_back({ok, IW'(mi), IW'(xi)});
    if (ok) begin
      for (int l = 0; l < N; l++) begin
        if (m_l2p[l] == mi)      m_l2p[l] = xi;
        else if (m_l2p[l] == xi) m_l2p[l] = mi;
      end
    end
    @(negedge clk);
    thresh = CW'(th);
    trig   = 1'b1;
    @(negedge clk);
    trig  = 1'b0;
    nbusy = 0;
    while (busy_o) begin
      nbusy++;
      if (poke_busy && nbusy == 3) trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
    end
    chk("R4 busy length", nbusy, N + 1);
    @(negedge clk);
    chk("R4 no restart", int'(busy_o), 0);
    chk("R4 queue drained", exp_q.size(), 0);
  endtask

  initial begin
    for (int b = 0; b < N; b++) begin
      m_cnt[b] = 0; m_fail[b] = 1'b0; m_l2p[b] = b;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 failed", int'(failed_o), 0);
    check_counts("R1 count");
    check_map("R1 map");

    // R2 counts [3,1,5,1,5,2,2,2]
    erase(0, 3); erase(1, 1); erase(2, 5); erase(3, 1);
    erase(4, 5); erase(5, 2); erase(6, 2); erase(7, 2);
    check_counts("R2 count");

    // R5 R6: tie on min (1,3) and max (2,4); spread 4 > 2 swaps 1 and 2
    level(2, 1'b0);
    check_map("R9 map after first swap");

    // R8: spread 4 not above 4, table unchanged
    level(4, 1'b0);
    check_map("R8 map unchanged");

    // R5 R9: block 1 becomes most worn; trigger during busy ignored (R4)
    erase(1, 10);
    chk("R2 single block", int'(m_cnt[1]), 11);
    level(0, 1'b1);
    check_map("R9 map after second swap");

    // R3: retire block 6, extra erases ignored
    erase(6, 25);
    rd_blk = IW'(6);
    #1;
    chk("R3 saturated count", int'(rd_cnt_o), LIM);
    chk("R3 failed bit", int'(failed_o[6]), 1);
    erase(6, 2);
    rd_blk = IW'(6);
    #1;
    chk("R3 no effect after retire", int'(rd_cnt_o), LIM);
    check_counts("R3 other counts");

    // R7: retired block 6 (highest) is skipped
    level(0, 1'b0);
    check_map("R7 map after swap");

    // R7 R6: retire 1 and 3; remaining mins tie
    erase(1, 20); erase(3, 20);
    level(1, 1'b0);
    check_map("R7 map final");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule